// File: doc/BRIEF.md
# Secure Translation Lookaside Buffer

This block is a fully associative translation cache for a processor with protected tasks. Each entry maps a virtual page to a physical page. Alongside the mapping it keeps the task that owns the page, a cipher key index, an encrypted-page flag, a certified-descriptor flag and two rights sets: one for the owner and one for any other task. The page walker loads an entry with a one-cycle fill. A lookup presents a virtual page number and an access kind. One cycle later the block reports a hit, a miss or a permission fault. On an encrypted hit it also returns the key index, so the cipher engine can load its key without help from software.

The running task identity is held inside the block and is loaded through a task-set strobe. When a different identity is loaded, every certified entry is dropped in that cycle and every other entry stays. A full-flush strobe clears the whole buffer in one cycle. Replacement first reuses free slots, searched from a rotating pointer, and falls back to plain round-robin once the buffer is full.

Top module: `sec_tlb`

## Requirements
- R1: After reset every entry is invalid, the running task is 0, `rsp_valid` is low, and the first lookup reports a miss.
- R2: A lookup presented in cycle N is answered in cycle N+1 with `rsp_valid` high and exactly one of `rsp_hit`, `rsp_miss`, `rsp_fault` high. Without a lookup, `rsp_valid` and all three flags are low.
- R3: Page size code 0 is a 4 KB page and all 20 VPN bits are compared. Code 1 is a 64 KB page and VPN bits [3:0] are ignored. Code 2 is a 1 MB page and VPN bits [7:0] are ignored. On a hit the ignored low bits of `rsp_ppn` are taken from the lookup VPN.
- R4: Rights fields use bit 0 for read, bit 1 for write and bit 2 for execute. Access code 0 is read, 1 is write, 2 is execute, and code 3 is never allowed. The owner rights apply when the running task equals the entry owner; otherwise the other-task rights apply.
- R5: A matching entry whose applicable rights forbid the access kind reports `rsp_fault` instead of a hit. On a fault or a miss, `rsp_ppn`, `rsp_key` and `rsp_enc` are zero.
- R6: A permitted hit on an encrypted entry returns `rsp_enc` = 1 and the stored key index on `rsp_key`. For any other result `rsp_key` is zero.
- R7: Loading a task identity that differs from the running one invalidates every certified entry and keeps every other entry. Loading the same identity changes nothing.
- R8: A lookup in the same cycle as a task load is judged with the newly loaded identity, against the entries that survive that load.
- R9: A full flush invalidates every entry in one cycle. A lookup in the same cycle reports a miss, and a fill in the same cycle is dropped.
- R10: A fill writes the first invalid slot found by searching upward, with wrap-around, from a rotating pointer. If no slot is invalid, it writes the slot under the pointer. After each fill the pointer moves to the slot after the one written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lk_valid | input | 1 | Lookup request |
| lk_vpn | input | 20 | Lookup virtual page number |
| lk_acc | input | 2 | Access kind: 0 read, 1 write, 2 execute |
| task_set | input | 1 | Load `task_id` as the running task |
| task_id | input | 16 | New running task identity |
| flush_all | input | 1 | Invalidate every entry |
| fill_valid | input | 1 | Write a new entry |
| fill_vpn | input | 20 | Virtual page number of the new entry |
| fill_ppn | input | 20 | Physical page number of the new entry |
| fill_size | input | 2 | Page size code |
| fill_owner | input | 16 | Owner task of the page |
| fill_key | input | 8 | Cipher key index |
| fill_enc | input | 1 | Page is encrypted |
| fill_cert | input | 1 | Descriptor is certified |
| fill_own_rights | input | 3 | Owner rights {x,w,r} |
| fill_oth_rights | input | 3 | Other-task rights {x,w,r} |
| rsp_valid | output | 1 | Response present |
| rsp_hit | output | 1 | Permitted hit |
| rsp_miss | output | 1 | No matching valid entry |
| rsp_fault | output | 1 | Match with forbidden access |
| rsp_ppn | output | 20 | Translated physical page number |
| rsp_key | output | 8 | Key index on an encrypted hit |
| rsp_enc | output | 1 | Hit is on an encrypted page |

## Verification
Several rules are checked on every cycle: the one-cycle response timing, the single result flag, the zero key on every non-encrypted result, the empty buffer after a full flush, the forced miss when a lookup meets a flush, the selective drop of certified entries with all others kept on an identity change, and the choice of a free victim whenever one exists. Some behaviours need whole sequences, and only the bench scenarios show them: the page-size masking and the merge of offset bits into the physical page, the choice between owner and other-task rights, which entry round-robin evicts once the buffer is full, and the use of the newly loaded identity by a lookup in the same cycle.

// File: rtl/sectlb_pkg.sv
package sectlb_pkg;
  parameter int VPN_W     = 20;
  parameter int PPN_W     = 20;
  parameter int TID_W     = 16;
  parameter int KEY_W     = 8;
  parameter int MID_SHIFT = 4;   // 64 KB page over 4 KB base
  parameter int BIG_SHIFT = 8;   // 1 MB page over 4 KB base

  typedef enum logic [1:0] {
    PG_SMALL = 2'd0,
    PG_MID   = 2'd1,
    PG_BIG   = 2'd2,
    PG_RSVD  = 2'd3
  } pgsz_e;

  typedef enum logic [1:0] {
    ACC_RD  = 2'd0,
    ACC_WR  = 2'd1,
    ACC_EX  = 2'd2,
    ACC_BAD = 2'd3
  } acc_e;

  typedef struct packed {
    logic [VPN_W-1:0] vpn;
    pgsz_e            size;
    logic [PPN_W-1:0] ppn;
    logic [TID_W-1:0] owner;
    logic [KEY_W-1:0] key;
    logic             enc;
    logic             cert;
    logic [2:0]       own_rw;
    logic [2:0]       oth_rw;
  } tlb_ent_t;

  // Low VPN bits that act as page offset for a given size.
  function automatic logic [VPN_W-1:0] size_mask(input pgsz_e s);
    case (s)
      PG_MID:  size_mask = VPN_W'((1 << MID_SHIFT) - 1);
      PG_BIG:  size_mask = VPN_W'((1 << BIG_SHIFT) - 1);
      default: size_mask = '0;
    endcase
  endfunction
endpackage

// File: rtl/sectlb_cmp.sv
module sectlb_cmp
  import sectlb_pkg::*;
(
  input  logic             valid,
  input  tlb_ent_t         ent,
  input  logic [VPN_W-1:0] vpn,
  output logic             match
);
  logic [VPN_W-1:0] keep;

  assign keep  = ~size_mask(ent.size);
  assign match = valid && (((ent.vpn ^ vpn) & keep) == '0);
endmodule

// File: rtl/sectlb_victim.sv
module sectlb_victim #(
  parameter int N  = 64,
  parameter int IW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [N-1:0]  valid_vec,
  input  logic          alloc,
  output logic [IW-1:0] pick
);
  logic [IW-1:0] ptr_q;
  logic          found;
  int            slot;

  // Free-slot search upward from the pointer, with wrap-around.
  always_comb begin
    found = 1'b0;
    pick  = ptr_q;
    slot  = 0;
    for (int i = 0; i < N; i++) begin
      slot = (int'(ptr_q) + i) % N;
      if (!found && !valid_vec[slot]) begin
        found = 1'b1;
        pick  = IW'(slot);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ptr_q <= '0;
    end else if (alloc) begin
      ptr_q <= (pick == IW'(N - 1)) ? '0 : pick + 1'b1;
    end
  end

  // R10
  free_first_chk: assert property (@(posedge clk) disable iff (rst)
    (alloc && !(&valid_vec)) |-> !valid_vec[pick]);
endmodule

// File: rtl/sectlb_perm.sv
module sectlb_perm
  import sectlb_pkg::*;
(
  input  logic             hit,
  input  tlb_ent_t         ent,
  input  logic [1:0]       acc,
  input  logic [TID_W-1:0] cur_task,
  input  logic [VPN_W-1:0] vpn,
  output logic             grant,
  output logic             fault,
  output logic [PPN_W-1:0] ppn,
  output logic [KEY_W-1:0] key,
  output logic             enc
);
  logic [2:0]       rights;
  logic             allowed;
  logic [PPN_W-1:0] off_m;

  assign rights = (cur_task == ent.owner) ? ent.own_rw : ent.oth_rw;

  always_comb begin
    case (acc_e'(acc))
      ACC_RD:  allowed = rights[0];
      ACC_WR:  allowed = rights[1];
      ACC_EX:  allowed = rights[2];
      default: allowed = 1'b0;
    endcase
  end

  assign off_m = PPN_W'(size_mask(ent.size));
  assign grant = hit && allowed;
  assign fault = hit && !allowed;
  assign ppn   = grant ? ((ent.ppn & ~off_m) | (PPN_W'(vpn) & off_m)) : '0;
  assign enc   = grant && ent.enc;
  assign key   = enc ? ent.key : '0;
endmodule

// File: rtl/sec_tlb.sv
module sec_tlb
  import sectlb_pkg::*;
#(
  parameter int ENTRIES = 64
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             lk_valid,
  input  logic [VPN_W-1:0] lk_vpn,
  input  logic [1:0]       lk_acc,
  input  logic             task_set,
  input  logic [TID_W-1:0] task_id,
  input  logic             flush_all,
  input  logic             fill_valid,
  input  logic [VPN_W-1:0] fill_vpn,
  input  logic [PPN_W-1:0] fill_ppn,
  input  logic [1:0]       fill_size,
  input  logic [TID_W-1:0] fill_owner,
  input  logic [KEY_W-1:0] fill_key,
  input  logic             fill_enc,
  input  logic             fill_cert,
  input  logic [2:0]       fill_own_rights,
  input  logic [2:0]       fill_oth_rights,
  output logic             rsp_valid,
  output logic             rsp_hit,
  output logic             rsp_miss,
  output logic             rsp_fault,
  output logic [PPN_W-1:0] rsp_ppn,
  output logic [KEY_W-1:0] rsp_key,
  output logic             rsp_enc
);
  localparam int IW = $clog2(ENTRIES);

  tlb_ent_t         ent_q [ENTRIES];
  logic [ENTRIES-1:0] valid_q, valid_eff, cert_vec, hit_vec;
  logic [TID_W-1:0] task_q, eff_task;
  logic             task_chg, do_fill, any_hit;
  logic [IW-1:0]    victim, hit_idx;
  tlb_ent_t         fill_ent, hit_ent;
  logic             p_grant, p_fault, p_enc;
  logic [PPN_W-1:0] p_ppn;
  logic [KEY_W-1:0] p_key;

  assign task_chg = task_set && (task_id != task_q);
  assign eff_task = task_set ? task_id : task_q;
  assign do_fill  = fill_valid && !flush_all;

  // Valid set as seen by this cycle's lookup and fill.
  always_comb begin
    if (flush_all)     valid_eff = '0;
    else if (task_chg) valid_eff = valid_q & ~cert_vec;
    else               valid_eff = valid_q;
  end

  for (genvar g = 0; g < ENTRIES; g++) begin : g_ent
    assign cert_vec[g] = ent_q[g].cert;
    sectlb_cmp u_cmp (
      .valid (valid_eff[g]),
      .ent   (ent_q[g]),
      .vpn   (lk_vpn),
      .match (hit_vec[g])
    );
  end

  // Lowest matching slot wins.
  always_comb begin
    any_hit = 1'b0;
    hit_idx = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (hit_vec[i]) begin
        any_hit = 1'b1;
        hit_idx = IW'(i);
      end
    end
  end

  assign hit_ent = ent_q[hit_idx];

  sectlb_victim #(.N(ENTRIES), .IW(IW)) u_victim (
    .clk       (clk),
    .rst       (rst),
    .valid_vec (valid_eff),
    .alloc     (do_fill),
    .pick      (victim)
  );

  sectlb_perm u_perm (
    .hit      (any_hit),
    .ent      (hit_ent),
    .acc      (lk_acc),
    .cur_task (eff_task),
    .vpn      (lk_vpn),
    .grant    (p_grant),
    .fault    (p_fault),
    .ppn      (p_ppn),
    .key      (p_key),
    .enc      (p_enc)
  );

  always_comb begin
    fill_ent.vpn    = fill_vpn;
    fill_ent.size   = pgsz_e'(fill_size);
    fill_ent.ppn    = fill_ppn;
    fill_ent.owner  = fill_owner;
    fill_ent.key    = fill_key;
    fill_ent.enc    = fill_enc;
    fill_ent.cert   = fill_cert;
    fill_ent.own_rw = fill_own_rights;
    fill_ent.oth_rw = fill_oth_rights;
  end

  // Entry storage: single write port, no reset.
  always_ff @(posedge clk) begin
    if (do_fill) ent_q[victim] <= fill_ent;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q <= '0;
      task_q  <= '0;
    end else begin
      valid_q <= valid_eff | (do_fill ? (ENTRIES'(1) << victim) : '0);
      task_q  <= eff_task;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      rsp_hit   <= 1'b0;
      rsp_miss  <= 1'b0;
      rsp_fault <= 1'b0;
      rsp_ppn   <= '0;
      rsp_key   <= '0;
      rsp_enc   <= 1'b0;
    end else begin
      rsp_valid <= lk_valid;
      rsp_hit   <= lk_valid && p_grant;
      rsp_miss  <= lk_valid && !any_hit;
      rsp_fault <= lk_valid && p_fault;
      rsp_ppn   <= lk_valid ? p_ppn : '0;
      rsp_key   <= lk_valid ? p_key : '0;
      rsp_enc   <= lk_valid && p_enc;
    end
  end

  // R2
  rsp_timing_chk: assert property (@(posedge clk) disable iff (rst)
    lk_valid |=> rsp_valid);
  // R2
  rsp_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !rsp_valid |-> !(rsp_hit || rsp_miss || rsp_fault));
  // R2
  one_flag_chk: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> $countones({rsp_hit, rsp_miss, rsp_fault}) == 1);
  // R6
  key_zero_chk: assert property (@(posedge clk) disable iff (rst)
    !rsp_enc |-> rsp_key == '0);
  // R6
  enc_hit_chk: assert property (@(posedge clk) disable iff (rst)
    rsp_enc |-> rsp_hit);
  // R9
  flush_empty_chk: assert property (@(posedge clk) disable iff (rst)
    flush_all |=> valid_q == '0);
  // R9
  flush_miss_chk: assert property (@(posedge clk) disable iff (rst)
    (lk_valid && flush_all) |=> rsp_miss);
  // R7
  cert_drop_chk: assert property (@(posedge clk) disable iff (rst)
    (task_chg && !flush_all && !fill_valid) |=> (valid_q & cert_vec) == '0);
  // R7
  plain_keep_chk: assert property (@(posedge clk) disable iff (rst)
    (task_chg && !flush_all && !fill_valid) |=>
      (valid_q & ~cert_vec) == ($past(valid_q) & ~cert_vec));
endmodule

// File: tb/sec_tlb_tb.sv
module sec_tlb_tb;
  logic        clk = 1'b0;
  logic        rst;
  logic        lk_valid, task_set, flush_all, fill_valid;
  logic [19:0] lk_vpn, fill_vpn, fill_ppn;
  logic [1:0]  lk_acc, fill_size;
  logic [15:0] task_id, fill_owner;
  logic [7:0]  fill_key;
  logic        fill_enc, fill_cert;
  logic [2:0]  fill_own_rights, fill_oth_rights;
  logic        rsp_valid, rsp_hit, rsp_miss, rsp_fault, rsp_enc;
  logic [19:0] rsp_ppn;
  logic [7:0]  rsp_key;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  sec_tlb u_dut (
    .clk(clk), .rst(rst), .lk_valid(lk_valid), .lk_vpn(lk_vpn), .lk_acc(lk_acc),
    .task_set(task_set), .task_id(task_id), .flush_all(flush_all),
    .fill_valid(fill_valid), .fill_vpn(fill_vpn), .fill_ppn(fill_ppn),
    .fill_size(fill_size), .fill_owner(fill_owner), .fill_key(fill_key),
    .fill_enc(fill_enc), .fill_cert(fill_cert), .fill_own_rights(fill_own_rights),
    .fill_oth_rights(fill_oth_rights), .rsp_valid(rsp_valid), .rsp_hit(rsp_hit),
    .rsp_miss(rsp_miss), .rsp_fault(rsp_fault), .rsp_ppn(rsp_ppn),
    .rsp_key(rsp_key), .rsp_enc(rsp_enc)
  );

  task automatic expect_rsp(input string req, input logic ev, input logic eh,
                            input logic em, input logic ef, input logic [19:0] ep,
                            input logic [7:0] ek, input logic ee);
    logic [32:0] act, exp;
    act = {rsp_valid, rsp_hit, rsp_miss, rsp_fault, rsp_enc, rsp_key, rsp_ppn};
    exp = {ev, eh, em, ef, ee, ek, ep};
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual v/h/m/f/e/key/ppn=%h expected %h", req, act, exp);
    end
  endtask

  task automatic look(input logic [19:0] v, input logic [1:0] a,
                      input logic ts, input logic [15:0] tid, input logic fl);
    @(negedge clk);
    lk_valid = 1'b1; lk_vpn = v; lk_acc = a;
    task_set = ts; task_id = tid; flush_all = fl;
    @(negedge clk);
    lk_valid = 1'b0; task_set = 1'b0; flush_all = 1'b0;
  endtask

  task automatic fill(input logic [19:0] v, input logic [19:0] p, input logic [1:0] sz,
                      input logic [15:0] own, input logic [7:0] k, input logic en,
                      input logic ce, input logic [2:0] orw, input logic [2:0] xrw,
                      input logic fl);
    @(negedge clk);
    fill_valid = 1'b1; fill_vpn = v; fill_ppn = p; fill_size = sz;
    fill_owner = own; fill_key = k; fill_enc = en; fill_cert = ce;
    fill_own_rights = orw; fill_oth_rights = xrw; flush_all = fl;
    @(negedge clk);
    fill_valid = 1'b0; flush_all = 1'b0;
  endtask

  task automatic set_task(input logic [15:0] tid);
    @(negedge clk);
    task_set = 1'b1; task_id = tid;
    @(negedge clk);
    task_set = 1'b0;
  endtask

  task automatic t_reset;
    expect_rsp("R1 idle after reset", 0, 0, 0, 0, 20'h0, 8'h0, 0);
    look(20'h00000, 2'd0, 0, 0, 0);
    expect_rsp("R1 first lookup misses", 1, 0, 1, 0, 20'h0, 8'h0, 0);
    @(negedge clk);
    expect_rsp("R2 no lookup no response", 0, 0, 0, 0, 20'h0, 8'h0, 0);
  endtask

  task automatic t_sizes;
    fill(20'h12345, 20'hABCDE, 2'd0, 16'd0, 8'h0, 0, 0, 3'b111, 3'b000, 0);
    fill(20'h20000, 20'h55550, 2'd1, 16'd0, 8'h0, 0, 0, 3'b111, 3'b000, 0);
    fill(20'h30000, 20'h77700, 2'd2, 16'd0, 8'h0, 0, 0, 3'b111, 3'b000, 0);
    look(20'h12345, 2'd0, 0, 0, 0);
    expect_rsp("R3 4K exact hit", 1, 1, 0, 0, 20'hABCDE, 8'h0, 0);
    look(20'h12346, 2'd0, 0, 0, 0);
    expect_rsp("R3 4K neighbour miss", 1, 0, 1, 0, 20'h0, 8'h0, 0);
    look(20'h2000F, 2'd0, 0, 0, 0);
    expect_rsp("R3 64K offset merge", 1, 1, 0, 0, 20'h5555F, 8'h0, 0);
    look(20'h20010, 2'd0, 0, 0, 0);
    expect_rsp("R3 64K outside miss", 1, 0, 1, 0, 20'h0, 8'h0, 0);
    look(20'h300A5, 2'd0, 0, 0, 0);
    expect_rsp("R3 1M offset merge", 1, 1, 0, 0, 20'h777A5, 8'h0, 0);
    look(20'h30100, 2'd0, 0, 0, 0);
    expect_rsp("R3 1M outside miss", 1, 0, 1, 0, 20'h0, 8'h0, 0);
  endtask

  task automatic t_rights;
    set_task(16'd5);
    fill(20'h40000, 20'h22222, 2'd0, 16'd5, 8'h0, 0, 0, 3'b011, 3'b001, 0);
    look(20'h40000, 2'd1, 0, 0, 0);
    expect_rsp("R4 owner write allowed", 1, 1, 0, 0, 20'h22222, 8'h0, 0);
    look(20'h40000, 2'd2, 0, 0, 0);
    expect_rsp("R5 owner exec fault", 1, 0, 0, 1, 20'h0, 8'h0, 0);
    look(20'h40000, 2'd3, 0, 0, 0);
    expect_rsp("R4 access code 3 fault", 1, 0, 0, 1, 20'h0, 8'h0, 0);
    set_task(16'd7);
    look(20'h40000, 2'd1, 0, 0, 0);
    expect_rsp("R4 other write fault", 1, 0, 0, 1, 20'h0, 8'h0, 0);
    look(20'h40000, 2'd0, 0, 0, 0);
    expect_rsp("R4 other read allowed", 1, 1, 0, 0, 20'h22222, 8'h0, 0);
  endtask

  task automatic t_key;
    fill(20'h50000, 20'h11111, 2'd0, 16'd7, 8'h3C, 1, 0, 3'b001, 3'b000, 0);
    fill(20'h51000, 20'h33333, 2'd0, 16'd7, 8'h77, 0, 0, 3'b111, 3'b000, 0);
    look(20'h50000, 2'd0, 0, 0, 0);
    expect_rsp("R6 encrypted hit key", 1, 1, 0, 0, 20'h11111, 8'h3C, 1);
    look(20'h50000, 2'd1, 0, 0, 0);
    expect_rsp("R6 encrypted fault no key", 1, 0, 0, 1, 20'h0, 8'h0, 0);
    look(20'h51000, 2'd0, 0, 0, 0);
    expect_rsp("R6 plain hit no key", 1, 1, 0, 0, 20'h33333, 8'h0, 0);
  endtask

  task automatic t_certflush;
    fill(20'h60000, 20'h44444, 2'd0, 16'd7, 8'h0, 0, 1, 3'b111, 3'b000, 0);
    fill(20'h61000, 20'h66666, 2'd0, 16'd7, 8'h0, 0, 0, 3'b111, 3'b001, 0);
    set_task(16'd7);
    look(20'h60000, 2'd0, 0, 0, 0);
    expect_rsp("R7 same id keeps certified", 1, 1, 0, 0, 20'h44444, 8'h0, 0);
    set_task(16'd9);
    look(20'h60000, 2'd0, 0, 0, 0);
    expect_rsp("R7 certified dropped", 1, 0, 1, 0, 20'h0, 8'h0, 0);
    look(20'h61000, 2'd0, 0, 0, 0);
    expect_rsp("R7 plain kept", 1, 1, 0, 0, 20'h66666, 8'h0, 0);
  endtask

  task automatic t_same_cycle_task;
    fill(20'h63000, 20'h12121, 2'd0, 16'd9, 8'h0, 0, 0, 3'b000, 3'b111, 0);
    look(20'h63000, 2'd0, 1, 16'd10, 0);
    expect_rsp("R8 new id used in same cycle", 1, 1, 0, 0, 20'h12121, 8'h0, 0);
    fill(20'h62000, 20'h34343, 2'd0, 16'd10, 8'h0, 0, 1, 3'b111, 3'b111, 0);
    look(20'h62000, 2'd0, 1, 16'd11, 0);
    expect_rsp("R8 certified gone in same cycle", 1, 0, 1, 0, 20'h0, 8'h0, 0);
  endtask

  task automatic t_flush;
    fill(20'h70000, 20'h56565, 2'd0, 16'd11, 8'h0, 0, 0, 3'b111, 3'b111, 0);
    look(20'h70000, 2'd0, 0, 0, 0);
    expect_rsp("R9 entry present", 1, 1, 0, 0, 20'h56565, 8'h0, 0);
    look(20'h70000, 2'd0, 0, 0, 1);
    expect_rsp("R9 same cycle flush miss", 1, 0, 1, 0, 20'h0, 8'h0, 0);
    look(20'h61000, 2'd0, 0, 0, 0);
    expect_rsp("R9 all entries gone", 1, 0, 1, 0, 20'h0, 8'h0, 0);
    fill(20'h71000, 20'h78787, 2'd0, 16'd11, 8'h0, 0, 0, 3'b111, 3'b111, 1);
    look(20'h71000, 2'd0, 0, 0, 0);
    expect_rsp("R9 fill dropped by flush", 1, 0, 1, 0, 20'h0, 8'h0, 0);
  endtask

  task automatic t_replace;
    for (int i = 0; i < 64; i++) begin
      fill(20'h80000 + 20'(i), 20'hC0000 + 20'(i), 2'd0, 16'd11, 8'h0, 0,
           (i == 10), 3'b111, 3'b111, 0);
    end
    set_task(16'd12);
    fill(20'h90000, 20'hD0000, 2'd0, 16'd12, 8'h0, 0, 0, 3'b111, 3'b111, 0);
    fill(20'h90001, 20'hD0001, 2'd0, 16'd12, 8'h0, 0, 0, 3'b111, 3'b111, 0);
    look(20'h80000, 2'd0, 0, 0, 0);
    expect_rsp("R10 freed slot reused first", 1, 1, 0, 0, 20'hC0000, 8'h0, 0);
    look(20'h8000B, 2'd0, 0, 0, 0);
    expect_rsp("R10 round robin evicts next", 1, 0, 1, 0, 20'h0, 8'h0, 0);
    look(20'h8000C, 2'd0, 0, 0, 0);
    expect_rsp("R10 later slot kept", 1, 1, 0, 0, 20'hC000C, 8'h0, 0);
    look(20'h90000, 2'd0, 0, 0, 0);
    expect_rsp("R10 first new entry", 1, 1, 0, 0, 20'hD0000, 8'h0, 0);
    look(20'h90001, 2'd0, 0, 0, 0);
    expect_rsp("R10 second new entry", 1, 1, 0, 0, 20'hD0001, 8'h0, 0);
  endtask

  initial begin
    rst = 1'b1;
    lk_valid = 0; lk_vpn = '0; lk_acc = '0; task_set = 0; task_id = '0; flush_all = 0;
    fill_valid = 0; fill_vpn = '0; fill_ppn = '0; fill_size = '0; fill_owner = '0;
    fill_key = '0; fill_enc = 0; fill_cert = 0; fill_own_rights = '0; fill_oth_rights = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_sizes();
    t_rights();
    t_key();
    t_certflush();
    t_same_cycle_task();
    t_flush();
    t_replace();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #1_000_000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual running expected finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule